// File: doc/BRIEF.md
# Oscillator Steering and Lock Detector

This block closes the slow loop of a disciplined oscillator. Once per measurement interval (nominally 100 seconds) an upstream counter delivers a signed frequency error, in counts, together with a one-cycle valid strobe. The block turns each error into an update of the control word of a trim DAC, and it judges from recent history whether the oscillator can be called locked.

Steering is nonlinear. Small errors give a nudge of a single DAC LSB toward the target. Larger errors give a jump of twice the error. Each LSB is worth about 370 ppt of trim, but the logic does not depend on that figure. For lock detection, the magnitudes of the ten most recent errors are kept in a circular window with a running sum. Lock is reported only after ten errors have arrived since reset, and only while the window sum stays below ten counts. That bound corresponds to about 1 ppb over 1000 seconds.

Top module: `osc_trim_steer`

## Requirements
- R1: A valid error that is nonzero with magnitude below 5 moves `dac_code` by exactly 1 toward correction. The new value appears one clock after the strobe.
- R2: A valid error with magnitude of 5 or more moves `dac_code` by twice its magnitude toward correction.
- R3: A valid error of zero, or any cycle with `err_valid` low, leaves `dac_code` unchanged.
- R4: With the default polarity parameter `POS_LOWERS`=1, a positive error (oscillator fast) lowers `dac_code` and a negative error raises it.
- R5: After reset, `dac_code` is mid-scale (0x8000 for 16 bits) and both `locked` and `win_full` are 0.
- R6: `dac_code` saturates at 0 and at 0xFFFF instead of wrapping. A correction that would pass either bound leaves the code at that bound.
- R7: The window holds the magnitudes of the last ten valid errors. `locked` is 1 exactly when the window is full and the sum of those magnitudes is below 10.
- R8: `win_full` is 0 until the tenth valid error after reset, and then stays 1. `locked` is never 1 while `win_full` is 0.
- R9: `locked` drops in the same cycle that the window sum reaches 10 or more. A sum of exactly 10 is not locked.
- R10: Each new error pushes the oldest one out of the window. The sum therefore forgets an error once ten later errors have arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | One-cycle strobe marking a new error |
| err | input | ERR_W (16) | Signed frequency error in counts |
| dac_code | output | DAC_W (16) | Trim DAC control word |
| locked | output | 1 | Long-term accuracy indication |
| win_full | output | 1 | Ten errors have been collected since reset |

## Verification
The bench targets the step-law boundary at magnitude 5. A design that handles it wrongly moves the code by 1 where it should move by 10. At both rails, an error larger than the remaining headroom is applied. A wrapping adder would jump from 0 to a high code, or from full scale to a low one. The lock tests check that the flag stays low through nine small errors. They check that a sum of exactly 10 is not locked, and that the window releases the oldest entry on the eleventh error, which a design without eviction never does. A pair of negative errors then lifts the sum back to 10. A signed sum would instead cancel to a negative value and report a false lock.

// File: rtl/osc_trim_steer.sv
module osc_trim_steer #(
  parameter int ERR_W       = 16,
  parameter int DAC_W       = 16,
  parameter int WIN         = 10,
  parameter int NUDGE_BELOW = 5,
  parameter int LOCK_BELOW  = 10,
  parameter bit POS_LOWERS  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err,
  output logic [DAC_W-1:0]        dac_code,
  output logic                    locked,
  output logic                    win_full
);

  localparam int IW    = $clog2(WIN);
  localparam int SUM_W = ERR_W + IW + 1;
  localparam int WW    = ((DAC_W > ERR_W) ? DAC_W : ERR_W) + 3;

  logic [ERR_W-1:0] mag;
  logic [ERR_W:0]   step;
  logic             lower;
  logic [WW-1:0]    cand;
  logic [DAC_W-1:0] dac_next;

  logic [ERR_W-1:0] win [WIN];
  logic [IW-1:0]    wr_ptr;
  logic [IW:0]      fill;
  logic [SUM_W-1:0] sum;

  assign mag   = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
  assign lower = (err[ERR_W-1] == 1'b0) == POS_LOWERS;

  always_comb begin
    if (err == '0)
      step = '0;
    else if (mag < ERR_W'(NUDGE_BELOW))
      step = (ERR_W+1)'(1);
    else
      step = {mag, 1'b0};
  end

  assign cand = lower ? (WW'(dac_code) - WW'(step)) : (WW'(dac_code) + WW'(step));

  always_comb begin
    if (cand[WW-1])
      dac_next = '0;
    else if (|cand[WW-2:DAC_W])
      dac_next = '1;
    else
      dac_next = cand[DAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dac_code <= {1'b1, {(DAC_W-1){1'b0}}};
    else if (err_valid)
      dac_code <= dac_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win[i] <= '0;
      wr_ptr <= '0;
      fill   <= '0;
      sum    <= '0;
    end else if (err_valid) begin
      win[wr_ptr] <= mag;
      wr_ptr      <= (wr_ptr == IW'(WIN-1)) ? '0 : wr_ptr + 1'b1;
      sum         <= sum + SUM_W'(mag) - SUM_W'(win[wr_ptr]);
      if (fill != (IW+1)'(WIN))
        fill <= fill + 1'b1;
    end
  end

  assign win_full = (fill == (IW+1)'(WIN));
  assign locked   = win_full && (sum < SUM_W'(LOCK_BELOW));

endmodule

// File: rtl/osc_trim_steer_chk.sv
module osc_trim_steer_chk #(
  parameter int ERR_W       = 16,
  parameter int DAC_W       = 16,
  parameter int NUDGE_BELOW = 5,
  parameter bit POS_LOWERS  = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    err_valid,
  input logic signed [ERR_W-1:0] err,
  input logic [DAC_W-1:0]        dac_code,
  input logic                    locked,
  input logic                    win_full
);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(dac_code));

  p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err == '0) |=> $stable(dac_code));

  p_nudge_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (POS_LOWERS && err_valid && err > 0 && err < NUDGE_BELOW && dac_code != '0)
      |=> dac_code == DAC_W'($past(dac_code) - 1'b1));

  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (POS_LOWERS && err_valid && err > 0 && dac_code == '0) |=> dac_code == '0);

  p_lock_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> win_full);

  p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_full |=> win_full);

endmodule

bind osc_trim_steer osc_trim_steer_chk #(
  .ERR_W(ERR_W), .DAC_W(DAC_W), .NUDGE_BELOW(NUDGE_BELOW), .POS_LOWERS(POS_LOWERS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err(err),
  .dac_code(dac_code), .locked(locked), .win_full(win_full)
);

// File: tb/test_osc_trim_steer.sv
module test_osc_trim_steer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               err_valid = 1'b0;
  logic signed [15:0] err = '0;
  logic [15:0]        dac_code;
  logic               locked;
  logic               win_full;

  int total = 0;
  int bad = 0;
  int exp_dac = 32768;
  int cycles = 0;

  osc_trim_steer i_osc_trim_steer (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err(err),
    .dac_code(dac_code), .locked(locked), .win_full(win_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int e);
    int a, s;
    a = (e < 0) ? -e : e;
    s = (e == 0) ? 0 : ((a < 5) ? 1 : 2 * a);
    exp_dac = (e > 0) ? exp_dac - s : exp_dac + s;
    if (exp_dac < 0) exp_dac = 0;
    if (exp_dac > 65535) exp_dac = 65535;
  endtask

  task automatic send(input int e);
    @(negedge clk);
    err_valid = 1'b1;
    err = 16'(e);
    @(negedge clk);
    err_valid = 1'b0;
    err = 16'(-3);
    model(e);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_dac = 32768;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R5 dac mid-scale", int'(dac_code), 32768);
    chk("R5 locked low", int'(locked), 0);
    chk("R5 win_full low", int'(win_full), 0);
  endtask

  task automatic t_small;
    do_reset();
    send(3);  chk("R1/R4 +3 lowers by 1", int'(dac_code), 32767);
    send(-2); chk("R1/R4 -2 raises by 1", int'(dac_code), 32768);
    send(-4); chk("R1 -4 raises by 1", int'(dac_code), 32769);
    send(1);  chk("R1 +1 lowers by 1", int'(dac_code), 32768);
  endtask

  task automatic t_large;
    do_reset();
    send(5);   chk("R2 boundary +5 lowers by 10", int'(dac_code), 32758);
    send(-6);  chk("R2/R4 -6 raises by 12", int'(dac_code), 32770);
    send(100); chk("R2 +100 lowers by 200", int'(dac_code), 32570);
    send(-5);  chk("R2 boundary -5 raises by 10", int'(dac_code), 32580);
  endtask

  task automatic t_hold;
    do_reset();
    send(-7);
    send(0);
    chk("R3 zero error holds", int'(dac_code), 32782);
    repeat (5) @(negedge clk);
    chk("R3 idle cycles hold (err bus nonzero)", int'(dac_code), 32782);
  endtask

  task automatic t_saturate;
    do_reset();
    send(32767);  chk("R6 floor clamp", int'(dac_code), 0);
    send(1);      chk("R6 stays at floor", int'(dac_code), 0);
    send(-32768); chk("R6 ceiling clamp", int'(dac_code), 65535);
    send(-1);     chk("R6 stays at ceiling", int'(dac_code), 65535);
    send(2);      chk("R6 leaves ceiling", int'(dac_code), 65534);
  endtask

  task automatic t_window;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      send(1);
      chk("R8 not full before tenth", int'(win_full), 0);
      chk("R8 no lock before full", int'(locked), 0);
    end
    send(1);
    chk("R8 full after tenth", int'(win_full), 1);
    chk("R9 sum of exactly 10 not locked", int'(locked), 0);
    chk("R4 dac after ten +1 errors", int'(dac_code), exp_dac);
    send(0);
    chk("R10 oldest evicted, sum 9 locks", int'(locked), 1);
    for (int i = 0; i < 8; i++) send(0);
    chk("R7 sum 1 locked", int'(locked), 1);
    send(-8);
    chk("R7 magnitude sum 8 locked", int'(locked), 1);
    send(-2);
    chk("R9 magnitude sum 10 drops lock", int'(locked), 0);
    chk("R8 full stays set", int'(win_full), 1);
  endtask

  initial begin
    t_reset();
    t_small();
    t_large();
    t_hold();
    t_saturate();
    t_window();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule